// File: doc/BRIEF.md
# Reset and Strobe Pin Controller

This block owns a single open-drain pad that does two jobs. Sensed as an input, the pad carries a long active-low reset from the board. Driven as an output, it carries a short active-low strobe that the controller emits when it is addressed on the serial bus and the transfer closes at once. The two uses are told apart only by pulse length. A counter of consecutive low samples asserts the internal reset after a long low. The block's own 8-cycle strobe never gets that far.

The internal reset, `sys_rst_o`, is a registered level for the rest of the controller. While it is high, the neighbouring registers load their defaults: the own-address and interrupt-vector registers go to 00H, the pending-interrupt and bus-busy flags go to 1, and every other control or status flag goes to 0. The strobe side takes one-cycle event pulses from the bus logic:

- `addr_match_i` means the own address or the general call was received.
- `data_bit_i` means a data bit followed the address.
- `stop_i` means a stop condition was seen.

`pin_i` is the pad level already synchronised to `clk_i`. When `pin_oe_o` is high, the pad pulls that level low.

Top module: `rststb_pin_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the release condition of R4 is met, `sys_rst_o` is 1 and `pin_oe_o` is 0.
- R2: After `pin_i` is sampled low on 30 consecutive rising edges, `sys_rst_o` becomes 1 directly after the 30th such edge, and not after the 29th.
- R3: A single high sample on `pin_i` restarts the low count. A run of 29 lows, or two runs of 20 lows split by one high, leaves `sys_rst_o` at 0.
- R4: Once asserted, `sys_rst_o` falls directly after the second of two consecutive rising edges at which `pin_i` is high. A single high sample between lows does not release it.
- R5: An `addr_match_i` pulse followed by a `stop_i` pulse, with no `data_bit_i` between them, drives `pin_oe_o` to 1 for exactly 8 cycles. The pulse starts directly after the edge that samples `stop_i`.
- R6: A `data_bit_i` pulse after the address match cancels the pending strobe. A `stop_i` with no pending match produces no pulse, and every `stop_i` clears the pending match.
- R7: While a strobe pulse is running, a new match followed by a stop neither extends it nor starts a second pulse later.
- R8: The block's own strobe low on the pad never asserts `sys_rst_o`.
- R9: While `sys_rst_o` is 1, `pin_oe_o` is 0 and event pulses are ignored. A match seen during reset does not survive into a strobe after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; must run during reset |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| pin_i | input | 1 | Synchronised level of the shared pad |
| addr_match_i | input | 1 | Pulse: own or general-call address received |
| data_bit_i | input | 1 | Pulse: data bit received after the address |
| stop_i | input | 1 | Pulse: stop condition seen |
| pin_oe_o | output | 1 | Pull the pad low (strobe active) |
| sys_rst_o | output | 1 | Synchronous internal reset, active high |

## Verification
A wrong low count shows at `sys_rst_o` one edge early or late against the 30th low sample. A filter that is not restarted by a high shows as a spurious reset after a broken low run. A stale arm flag or a wrong strobe counter shows at `pin_oe_o` as a pulse after a cancelled or orphaned stop, or as a pulse of some length other than 8. The bench compares both outputs on every cycle of each window, so any such fault appears within one clock of the expected edge.

// File: rtl/rststb_pkg.sv
package rststb_pkg;
  localparam int unsigned FILT_LEN = 30;  // consecutive lows that mean reset
  localparam int unsigned STB_LEN  = 8;   // strobe width in clocks
  localparam int unsigned REL_LEN  = 2;   // consecutive highs that release reset
endpackage

// File: rtl/rststb_filter.sv
module rststb_filter #(
  parameter int unsigned FILT_LEN = rststb_pkg::FILT_LEN,
  parameter int unsigned REL_LEN  = rststb_pkg::REL_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rst_o,
  output logic rst_next_o
);
  localparam int unsigned LW = $clog2(FILT_LEN + 1);
  localparam int unsigned HW = $clog2(REL_LEN + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(FILT_LEN);
  localparam logic [HW-1:0] HI_MAX  = HW'(REL_LEN);

  logic [LW-1:0] low_q, low_d;
  logic [HW-1:0] hi_q, hi_d;
  logic          rst_q, rst_d;

  always_comb begin
    if (pin_i)                low_d = '0;
    else if (low_q == LOW_MAX) low_d = low_q;
    else                      low_d = low_q + LW'(1);

    if (!rst_q || !pin_i)     hi_d = '0;
    else if (hi_q == HI_MAX)  hi_d = hi_q;
    else                      hi_d = hi_q + HW'(1);

    rst_d = rst_q;
    if (low_d == LOW_MAX)     rst_d = 1'b1;
    else if (hi_d == HI_MAX)  rst_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
      hi_q  <= '0;
      rst_q <= 1'b1;
    end else begin
      low_q <= low_d;
      hi_q  <= hi_d;
      rst_q <= rst_d;
    end
  end

  assign rst_o      = rst_q;
  assign rst_next_o = rst_d;

  AST_RST_RISE_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> !$past(pin_i)); // R2
  AST_RELEASE_TWO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> $past(pin_i) && $past(pin_i, 2)); // R4
endmodule

// File: rtl/rststb_strobe.sv
module rststb_strobe #(
  parameter int unsigned STB_LEN = rststb_pkg::STB_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic addr_match_i,
  input  logic data_bit_i,
  input  logic stop_i,
  output logic oe_o
);
  localparam int unsigned CW = $clog2(STB_LEN + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(STB_LEN);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          start;

  assign start = !clr_i && stop_i && armed_q && (cnt_q == '0);

  always_comb begin
    // clearing events take precedence over a fresh match
    if (clr_i || data_bit_i || stop_i) armed_d = 1'b0;
    else if (addr_match_i)             armed_d = 1'b1;
    else                               armed_d = armed_q;

    if (clr_i)               cnt_d = '0;
    else if (start)          cnt_d = CNT_LOAD;
    else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign oe_o = (cnt_q != '0);

  // checker: length of the current run of drive cycles
  logic [CW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= '0;
    else if (!oe_o)                  run_q <= '0;
    else if (run_q != CNT_LOAD)      run_q <= run_q + CW'(1);
  end

  AST_STROBE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(stop_i) && $past(armed_q)); // R5
  AST_STROBE_NO_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> run_q < CNT_LOAD); // R7
  AST_STROBE_FULL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(oe_o) && !$past(clr_i)) |-> run_q == CNT_LOAD); // R5
endmodule

// File: rtl/rststb_pin_ctrl.sv
module rststb_pin_ctrl #(
  parameter int unsigned FILT_LEN = rststb_pkg::FILT_LEN,
  parameter int unsigned STB_LEN  = rststb_pkg::STB_LEN,
  parameter int unsigned REL_LEN  = rststb_pkg::REL_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic addr_match_i,
  input  logic data_bit_i,
  input  logic stop_i,
  output logic pin_oe_o,
  output logic sys_rst_o
);
  logic rst_next;

  rststb_filter #(.FILT_LEN(FILT_LEN), .REL_LEN(REL_LEN)) i_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .rst_o      (sys_rst_o),
    .rst_next_o (rst_next)
  );

  rststb_strobe #(.STB_LEN(STB_LEN)) i_strobe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (rst_next),
    .addr_match_i (addr_match_i),
    .data_bit_i   (data_bit_i),
    .stop_i       (stop_i),
    .oe_o         (pin_oe_o)
  );

  // checker: consecutive low samples of the pad, independent of the filter
  localparam int unsigned SW = $clog2(FILT_LEN + 2);
  localparam logic [SW-1:0] SEEN_MAX = SW'(FILT_LEN + 1);
  logic [SW-1:0] low_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    low_seen_q <= '0;
    else if (pin_i)                 low_seen_q <= '0;
    else if (low_seen_q != SEEN_MAX) low_seen_q <= low_seen_q + SW'(1);
  end

  AST_RST_NEEDS_FULL_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> low_seen_q == SW'(FILT_LEN)); // R3
  AST_NO_DRIVE_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !pin_oe_o); // R9
endmodule

// File: tb/test_rststb_pin_ctrl.sv
module test_rststb_pin_ctrl;
  logic clk = 1'b0;
  logic rst_n, ext_n, addr, data, stop;
  logic pin, oe, srst;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  assign pin = ext_n & ~oe;

  rststb_pin_ctrl i_rststb_pin_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pin_i        (pin),
    .addr_match_i (addr),
    .data_bit_i   (data),
    .stop_i       (stop),
    .pin_oe_o     (oe),
    .sys_rst_o    (srst)
  );

  typedef struct {
    int    at;
    bit    r;
    bit    o;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic expect_at(input int ofs, input bit r, input bit o, input string tag);
    exp_t e;
    e.at = cyc + ofs; e.r = r; e.o = o; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_now(input bit r, input bit o, input string tag);
    checks++;
    if (srst !== r || oe !== o) begin
      errors++;
      $display("FAIL %s cyc %0d: rst=%b oe=%b expected rst=%b oe=%b", tag, cyc, srst, oe, r, o);
    end
  endtask

  // monitor: compare every scheduled item due this cycle
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].at == cyc) begin
        check_now(exp_q[i].r, exp_q[i].o, exp_q[i].tag);
        exp_q.delete(i);
      end
    end
  end

  initial begin
    for (int w = 0; w < 200000; w++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_n = 1'b1; addr = 1'b0; data = 1'b0; stop = 1'b0;
    step(3);
    check_now(1'b1, 1'b0, "R1");
    rst_n = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R1");
    expect_at(2, 1'b0, 1'b0, "R4");
    step(4);

    // R5 / R8: match then stop gives an 8-cycle strobe, no reset
    addr = 1'b1; step(1); addr = 1'b0; stop = 1'b1;
    for (int k = 1; k <= 8; k++) expect_at(k, 1'b0, 1'b1, "R5");
    expect_at(9, 1'b0, 1'b0, "R5");
    for (int k = 10; k <= 14; k++) expect_at(k, 1'b0, 1'b0, "R8");
    step(1); stop = 1'b0; step(16);

    // R6: data bit cancels the pending strobe
    addr = 1'b1; step(1); addr = 1'b0; data = 1'b1; step(1); data = 1'b0; stop = 1'b1;
    for (int k = 1; k <= 10; k++) expect_at(k, 1'b0, 1'b0, "R6");
    step(1); stop = 1'b0; step(12);

    // R6: stop without a prior match
    stop = 1'b1;
    for (int k = 1; k <= 10; k++) expect_at(k, 1'b0, 1'b0, "R6");
    step(1); stop = 1'b0; step(12);

    // R7: match and stop during a running strobe
    addr = 1'b1; step(1); addr = 1'b0; stop = 1'b1;
    for (int k = 1; k <= 8; k++) expect_at(k, 1'b0, 1'b1, "R7");
    for (int k = 9; k <= 16; k++) expect_at(k, 1'b0, 1'b0, "R7");
    step(1); stop = 1'b0; step(2);
    addr = 1'b1; step(1); addr = 1'b0; stop = 1'b1; step(1); stop = 1'b0;
    step(16);

    // R3: 29 lows do not reset
    ext_n = 1'b0;
    for (int k = 1; k <= 32; k++) expect_at(k, 1'b0, 1'b0, "R3");
    step(29); ext_n = 1'b1; step(5);

    // R3: 20 lows, one high, 20 lows
    ext_n = 1'b0;
    for (int k = 1; k <= 44; k++) expect_at(k, 1'b0, 1'b0, "R3");
    step(20); ext_n = 1'b1; step(1); ext_n = 1'b0; step(20); ext_n = 1'b1; step(5);

    // R2: the 30th consecutive low asserts reset
    ext_n = 1'b0;
    expect_at(29, 1'b0, 1'b0, "R2");
    expect_at(30, 1'b1, 1'b0, "R2");
    step(31);

    // R9: events during reset are ignored
    addr = 1'b1; step(1); addr = 1'b0; stop = 1'b1;
    for (int k = 1; k <= 10; k++) expect_at(k, 1'b1, 1'b0, "R9");
    step(1); stop = 1'b0; step(2);
    addr = 1'b1; step(1); addr = 1'b0;
    step(10);

    // R4: one high between lows does not release
    ext_n = 1'b1;
    for (int k = 1; k <= 4; k++) expect_at(k, 1'b1, 1'b0, "R4");
    step(1); ext_n = 1'b0; step(5);

    // R4: two consecutive highs release
    ext_n = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R4");
    expect_at(2, 1'b0, 1'b0, "R4");
    step(4);

    // R9: match seen during reset does not survive release
    stop = 1'b1;
    for (int k = 1; k <= 10; k++) expect_at(k, 1'b0, 1'b0, "R9");
    step(1); stop = 1'b0; step(12);

    // R5: strobe works again after release
    addr = 1'b1; step(1); addr = 1'b0; stop = 1'b1;
    for (int k = 1; k <= 8; k++) expect_at(k, 1'b0, 1'b1, "R5");
    expect_at(9, 1'b0, 1'b0, "R5");
    step(1); stop = 1'b0; step(12);

    while (exp_q.size() > 0) step(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule